// File: doc/BRIEF.md
# Conditional Branch and Program Counter Unit

This block decides whether an instruction executes and where the program goes next. It checks each instruction's 4-bit predicate against the N, Z, C and V flags. For branch instructions it works out the target address and, when asked, the return address to store. For loads that address relative to the program counter it produces the effective address.

The block sits beside the execute stage of a three-stage fetch/decode/execute core. It reproduces only the program counter offset that such a pipeline makes visible: an executing instruction sees its own address plus 8. Flag generation, memory access and the pipeline registers themselves live elsewhere.

Every result is registered. A request presented with `valid_i` at one rising edge appears on the outputs after that edge, together with `out_valid_o`.

Top module: `branch_pc_unit`

## Requirements
- R1: In the cycle after a synchronous active-high reset, `out_valid_o`, `cond_pass_o`, `br_taken_o`, `link_we_o` and `pcrel_valid_o` are 0, and `next_pc_o`, `link_val_o` and `pcrel_addr_o` are 0.
- R2: The predicate is `instr_i[31:28]`. The codes pass as follows:
  - 0000 when Z=1; 0001 when Z=0.
  - 0010 when C=1; 0011 when C=0.
  - 0100 when N=1; 0101 when N=0.
  - 0110 when V=1; 0111 when V=0.
  - 1000 when C=1 and Z=0; 1001 when C=0 or Z=1.
  - 1010 when N equals V; 1011 when N differs from V.
  - 1100 when Z=0 and N equals V; 1101 when Z=1 or N differs from V.
  - 1110 always.

  `cond_pass_o` reports the result for every valid instruction.
- R3: Predicate 1111 never passes. Such an instruction produces no branch, no link write and no PC-relative address.
- R4: An instruction with `instr_i[27:25]` = 101 is a branch. Bits 23:0 hold a signed word offset. When the predicate passes, `br_taken_o` is 1 and `next_pc_o` is the instruction address + 8 + offset×4, modulo 2^32. For example, 0xEAFFFFFE branches to its own address.
- R5: When the instruction is not a branch, or its predicate fails, `br_taken_o` is 0 and `next_pc_o` is the instruction address + 4.
- R6: When a branch is taken and bit 24 is 1, `link_we_o` is 1 and `link_val_o` is the instruction address + 4. These are the write enable and value for register 14. A failed predicate, or bit 24 = 0, leaves `link_we_o` at 0.
- R7: A PC-relative load matches all of the following:
  - `instr_i[27:26]` = 01
  - bit 25 = 0 (immediate offset)
  - bit 20 = 1 (load)
  - bits 19:16 = 1111

  When its predicate passes, `pcrel_valid_o` is 1. `pcrel_addr_o` is the instruction address + 8 plus the 12-bit immediate in bits 11:0 when bit 23 is 1, or minus it when bit 23 is 0. Any other instruction gives `pcrel_valid_o` = 0.
- R8: Outputs change one clock after the inputs are sampled. With `valid_i` = 0, `out_valid_o`, `cond_pass_o`, `br_taken_o`, `link_we_o` and `pcrel_valid_o` are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | ADDR_W | Address of the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| out_valid_o | output | 1 | Registered results are valid |
| cond_pass_o | output | 1 | Predicate passed |
| br_taken_o | output | 1 | Branch taken |
| next_pc_o | output | ADDR_W | Address of the next instruction |
| link_we_o | output | 1 | Write return address to register 14 |
| link_val_o | output | ADDR_W | Return address |
| pcrel_valid_o | output | 1 | PC-relative load address is valid |
| pcrel_addr_o | output | ADDR_W | PC-relative load effective address |

## Verification
The embedded assertions check on every cycle the invariants that do not depend on the arithmetic:
- a taken branch and a link write never appear without valid output;
- a link write implies a taken branch and carries the sampled address + 4;
- a non-taken result always steps by 4;
- code 1110 always passes and code 1111 never does;
- an idle input gives an idle output.

Only the bench's scenarios show the rest. It sweeps every predicate against every flag combination, covering each row of the condition table. It also covers the sign extension and wraparound of branch offsets, and the up/down immediate of PC-relative loads. Finally it confirms that look-alike encodings (stores, other base registers, register offsets) are rejected.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  localparam int INSTR_W     = 32;
  localparam int PIPE_AHEAD  = 8;
  localparam int INSTR_BYTES = 4;
  localparam int COND_W      = 4;

  localparam logic [2:0] BR_CLASS = 3'b101;
  localparam logic [1:0] LS_CLASS = 2'b01;
  localparam logic [3:0] PC_REG   = 4'd15;

  typedef enum logic [COND_W-1:0] {
    PRED_EQ = 4'h0, PRED_NE = 4'h1, PRED_CS = 4'h2, PRED_CC = 4'h3,
    PRED_MI = 4'h4, PRED_PL = 4'h5, PRED_VS = 4'h6, PRED_VC = 4'h7,
    PRED_HI = 4'h8, PRED_LS = 4'h9, PRED_GE = 4'hA, PRED_LT = 4'hB,
    PRED_GT = 4'hC, PRED_LE = 4'hD, PRED_AL = 4'hE, PRED_NV = 4'hF
  } pred_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/bpu_cond_eval.sv
module bpu_cond_eval
  import bpu_pkg::*;
(
  input  pred_e  pred_i,
  input  flags_t flags_i,
  output logic   pass_o
);

  logic sign_ok;
  assign sign_ok = (flags_i.n == flags_i.v);

  always_comb begin
    pass_o = 1'b0;
    case (pred_i)
      PRED_EQ: pass_o =  flags_i.z;
      PRED_NE: pass_o = !flags_i.z;
      PRED_CS: pass_o =  flags_i.c;
      PRED_CC: pass_o = !flags_i.c;
      PRED_MI: pass_o =  flags_i.n;
      PRED_PL: pass_o = !flags_i.n;
      PRED_VS: pass_o =  flags_i.v;
      PRED_VC: pass_o = !flags_i.v;
      PRED_HI: pass_o =  flags_i.c && !flags_i.z;
      PRED_LS: pass_o = !flags_i.c ||  flags_i.z;
      PRED_GE: pass_o =  sign_ok;
      PRED_LT: pass_o = !sign_ok;
      PRED_GT: pass_o = !flags_i.z &&  sign_ok;
      PRED_LE: pass_o =  flags_i.z || !sign_ok;
      PRED_AL: pass_o = 1'b1;
      PRED_NV: pass_o = 1'b0;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/bpu_target_calc.sv
module bpu_target_calc
  import bpu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 24
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] seq_o
);

  localparam int                EXT_W = ADDR_W - OFF_W - 2;
  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PIPE_AHEAD);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] byte_off;

  generate
    if (EXT_W > 0) begin : g_ext
      assign byte_off = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
    end else begin : g_trunc
      assign byte_off = ADDR_W'({offset_i, 2'b00});
    end
  endgenerate

  assign target_o = pc_i + AHEAD + byte_off;
  assign seq_o    = pc_i + STEP;

endmodule

// File: rtl/bpu_pcrel_agen.sv
module bpu_pcrel_agen
  import bpu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              up_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] AHEAD = ADDR_W'(PIPE_AHEAD);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] imm_ext;

  assign base    = pc_i + AHEAD;
  assign imm_ext = ADDR_W'(imm_i);
  assign addr_o  = up_i ? (base + imm_ext) : (base - imm_ext);

endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import bpu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 24,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              flag_v_i,
  output logic              out_valid_o,
  output logic              cond_pass_o,
  output logic              br_taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              link_we_o,
  output logic [ADDR_W-1:0] link_val_o,
  output logic              pcrel_valid_o,
  output logic [ADDR_W-1:0] pcrel_addr_o
);

  localparam int COND_LSB = INSTR_W - COND_W;
  localparam int LINK_BIT = OFF_W;
  localparam int UP_BIT   = 23;
  localparam int LOAD_BIT = 20;
  localparam int RN_LSB   = 16;

  flags_t            flags;
  pred_e             pred;
  logic              pass;
  logic              is_branch;
  logic              is_pcrel;
  logic              take;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] ld_addr;

  assign flags     = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};
  assign pred      = pred_e'(instr_i[INSTR_W-1:COND_LSB]);
  assign is_branch = (instr_i[27:25] == BR_CLASS);
  assign is_pcrel  = (instr_i[27:26] == LS_CLASS) && !instr_i[25]
                     && instr_i[LOAD_BIT] && (instr_i[RN_LSB+3:RN_LSB] == PC_REG);
  assign take      = valid_i && pass && is_branch;

  bpu_cond_eval u_cond (
    .pred_i  (pred),
    .flags_i (flags),
    .pass_o  (pass)
  );

  bpu_target_calc #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_target (
    .pc_i     (pc_i),
    .offset_i (instr_i[OFF_W-1:0]),
    .target_o (target),
    .seq_o    (seq_pc)
  );

  bpu_pcrel_agen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_agen (
    .pc_i   (pc_i),
    .imm_i  (instr_i[IMM_W-1:0]),
    .up_i   (instr_i[UP_BIT]),
    .addr_o (ld_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o   <= 1'b0;
      cond_pass_o   <= 1'b0;
      br_taken_o    <= 1'b0;
      next_pc_o     <= '0;
      link_we_o     <= 1'b0;
      link_val_o    <= '0;
      pcrel_valid_o <= 1'b0;
      pcrel_addr_o  <= '0;
    end else begin
      out_valid_o   <= valid_i;
      cond_pass_o   <= valid_i && pass;
      br_taken_o    <= take;
      next_pc_o     <= take ? target : seq_pc;
      link_we_o     <= take && instr_i[LINK_BIT];
      link_val_o    <= seq_pc;
      pcrel_valid_o <= valid_i && pass && is_pcrel;
      pcrel_addr_o  <= ld_addr;
    end
  end

  // R8
  taken_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken_o |-> out_valid_o);

  // R8
  idle_in_idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!out_valid_o && !br_taken_o && !link_we_o && !pcrel_valid_o));

  // R6
  link_implies_taken_chk: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> br_taken_o);

  // R6
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_val_o == $past(pc_i) + ADDR_W'(INSTR_BYTES)));

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !br_taken_o) |-> (next_pc_o == $past(pc_i) + ADDR_W'(INSTR_BYTES)));

  // R2
  always_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[31:28] == 4'hE) |=> cond_pass_o);

  // R3
  never_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_i && instr_i[31:28] == 4'hF) |=> (!cond_pass_o && !br_taken_o && !pcrel_valid_o));

endmodule

// File: tb/branch_pc_unit_tb.sv
module branch_pc_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [31:0] instr_i;
  logic [31:0] pc_i;
  logic        fn, fz, fc, fv;
  logic        out_valid_o, cond_pass_o, br_taken_o, link_we_o, pcrel_valid_o;
  logic [31:0] next_pc_o, link_val_o, pcrel_addr_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  branch_pc_unit u_dut (
    .clk (clk), .rst (rst), .valid_i (valid_i), .instr_i (instr_i), .pc_i (pc_i),
    .flag_n_i (fn), .flag_z_i (fz), .flag_c_i (fc), .flag_v_i (fv),
    .out_valid_o (out_valid_o), .cond_pass_o (cond_pass_o), .br_taken_o (br_taken_o),
    .next_pc_o (next_pc_o), .link_we_o (link_we_o), .link_val_o (link_val_o),
    .pcrel_valid_o (pcrel_valid_o), .pcrel_addr_o (pcrel_addr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                       input logic [3:0] nzcv);
    @(negedge clk);
    valid_i = v; instr_i = ins; pc_i = pc;
    {fn, fz, fc, fv} = nzcv;
    @(negedge clk);
  endtask

  function automatic bit exp_pass(input int code, input logic [3:0] nzcv);
    bit n, z, c, v, b;
    {n, z, c, v} = nzcv;
    case (code >> 1)
      0: b = z;
      1: b = c;
      2: b = n;
      3: b = v;
      4: b = c && !z;
      5: b = (n == v);
      6: b = !z && (n == v);
      default: return code == 14;
    endcase
    return (code % 2 == 1) ? !b : b;
  endfunction

  function automatic logic [31:0] exp_target(input logic [31:0] pc, input logic [23:0] off);
    longint s;
    s = (off >= 24'h800000) ? longint'(off) - 64'sd16777216 : longint'(off);
    return 32'(longint'(pc) + 8 + s * 4);
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; valid_i = 1'b0; instr_i = '0; pc_i = '0; {fn, fz, fc, fv} = 4'h0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", {31'd0, out_valid_o}, 32'd0);
    chk("R1 flags", {27'd0, cond_pass_o, br_taken_o, link_we_o, pcrel_valid_o, 1'b0}, 32'd0);
    chk("R1 next_pc", next_pc_o, 32'd0);
    chk("R1 link_val", link_val_o, 32'd0);
    chk("R1 pcrel_addr", pcrel_addr_o, 32'd0);
    rst = 1'b0;

    // R2 R3 R4 R5: every predicate against every flag set, using a branch
    for (int code = 0; code < 16; code++) begin
      for (int fl = 0; fl < 16; fl++) begin
        logic [31:0] ins;
        bit p;
        ins = {4'(code), 3'b101, 1'b0, 24'h000010};
        p = exp_pass(code, 4'(fl));
        apply(1'b1, ins, 32'h0000_1000, 4'(fl));
        chk(code == 15 ? "R3 cond_pass" : "R2 cond_pass", {31'd0, cond_pass_o}, {31'd0, p});
        chk("R4 br_taken", {31'd0, br_taken_o}, {31'd0, p});
        chk(p ? "R4 next_pc" : "R5 next_pc", next_pc_o, p ? 32'h0000_1048 : 32'h0000_1004);
        chk("R6 no link", {31'd0, link_we_o}, 32'd0);
      end
    end

    // R4 offsets: self loop, extremes, wraparound
    apply(1'b1, 32'hEAFF_FFFE, 32'h0000_0018, 4'h0);
    chk("R4 self branch", next_pc_o, 32'h0000_0018);
    begin
      logic [23:0] offs [5] = '{24'h800000, 24'h7FFFFF, 24'hFFFFFF, 24'h000001, 24'h000000};
      logic [31:0] pcs  [5] = '{32'h0200_0000, 32'h0000_0100, 32'h8000_0000, 32'hFFFF_FFF4, 32'h0000_0040};
      for (int i = 0; i < 5; i++) begin
        apply(1'b1, {8'hEA, offs[i]}, pcs[i], 4'h0);
        chk("R4 target", next_pc_o, exp_target(pcs[i], offs[i]));
        chk("R4 taken", {31'd0, br_taken_o}, 32'd1);
      end
    end

    // R6 link
    apply(1'b1, 32'hEB00_0004, 32'h0000_2000, 4'h0);
    chk("R6 link_we", {31'd0, link_we_o}, 32'd1);
    chk("R6 link_val", link_val_o, 32'h0000_2004);
    chk("R6 link target", next_pc_o, 32'h0000_2018);
    apply(1'b1, 32'h0B00_0004, 32'h0000_2000, 4'h0);  // EQ with Z=0 fails
    chk("R6 failed link", {31'd0, link_we_o}, 32'd0);
    chk("R5 failed branch pc", next_pc_o, 32'h0000_2004);
    apply(1'b1, 32'h1B00_0004, 32'h0000_3000, 4'h0);  // NE with Z=0 passes
    chk("R6 NE link", {31'd0, link_we_o}, 32'd1);

    // R7 PC-relative loads
    apply(1'b1, 32'hE59F_0014, 32'h0000_0000, 4'h0);
    chk("R7 pcrel_valid", {31'd0, pcrel_valid_o}, 32'd1);
    chk("R7 pcrel_addr", pcrel_addr_o, 32'h0000_001C);
    chk("R5 load next_pc", next_pc_o, 32'h0000_0004);
    apply(1'b1, 32'hE59F_000C, 32'h0000_000C, 4'h0);
    chk("R7 pcrel_addr 2", pcrel_addr_o, 32'h0000_0020);
    apply(1'b1, 32'hE51F_0010, 32'h0000_0100, 4'h0);
    chk("R7 down addr", pcrel_addr_o, 32'h0000_00F8);
    chk("R7 down valid", {31'd0, pcrel_valid_o}, 32'd1);
    apply(1'b1, 32'hE591_0014, 32'h0000_0000, 4'h0);
    chk("R7 other base", {31'd0, pcrel_valid_o}, 32'd0);
    apply(1'b1, 32'hE58F_0014, 32'h0000_0000, 4'h0);
    chk("R7 store", {31'd0, pcrel_valid_o}, 32'd0);
    apply(1'b1, 32'hE79F_0001, 32'h0000_0000, 4'h0);
    chk("R7 reg offset", {31'd0, pcrel_valid_o}, 32'd0);
    apply(1'b1, 32'h059F_0014, 32'h0000_0000, 4'h0);
    chk("R7 cond fail", {31'd0, pcrel_valid_o}, 32'd0);
    apply(1'b1, 32'hF59F_0014, 32'h0000_0000, 4'hF);
    chk("R3 never load", {31'd0, pcrel_valid_o}, 32'd0);

    // R8 idle input
    apply(1'b0, 32'hEB00_0004, 32'h0000_4000, 4'h0);
    chk("R8 out_valid", {31'd0, out_valid_o}, 32'd0);
    chk("R8 idle flags", {28'd0, cond_pass_o, br_taken_o, link_we_o, pcrel_valid_o}, 32'd0);
    apply(1'b1, 32'hE3A0_1001, 32'h0000_4000, 4'h0);
    chk("R8 out_valid back", {31'd0, out_valid_o}, 32'd1);
    chk("R5 non-branch", next_pc_o, 32'h0000_4004);

    done = 1'b1;
    finish_run();
  end

endmodule